// File: doc/BRIEF.md
# VGA Raster Timing Controller

This block produces the scan timing for a 640 by 480 picture drawn from a 25 MHz pixel clock. Two free-running counters locate the beam: a column counter that steps on every clock, and a row counter that steps once per line. Decoding the two counters gives active-low horizontal and vertical sync pulses and a visible-area flag.

While the beam is inside the picture, the counters also form a linear address into an external video RAM. That RAM holds one 8-bit pixel per location, packed as 3 bits red, 3 bits green and 2 bits blue. The RAM returns the pixel one clock after the address. The block splits the pixel onto the colour pins and forces it to black during blanking. The sync pulses are delayed to match, so that all ten output pins change on the same clock edge and come straight from registers.

Every timing figure is a parameter, so a smaller raster can be built for test.

Top module: `vga_raster_ctrl`

## Requirements
- R1: `rst_n` is a synchronous, active-low reset. It clears both counters to zero. On the clock after a reset edge, `hsync_n_o` and `vsync_n_o` are 1, all colour outputs are 0 and `pix_addr_o` is 0.
- R2: The column counter counts 0 to H_TOTAL-1 and then wraps to 0. H_TOTAL = H_ACTIVE+H_FRONT+H_PULSE+H_BACK, which is 800 by default. Successive falling edges of `hsync_n_o` are exactly H_TOTAL clocks apart.
- R3: `hsync_n_o` is 0 exactly while the column, two clocks earlier, was in the range H_ACTIVE+H_FRONT up to but not including H_ACTIVE+H_FRONT+H_PULSE. By default that range is 656 to 751, so each low pulse lasts H_PULSE clocks (96 by default).
- R4: The row counter advances by one only on the clock where the column counter steps into the horizontal sync range, and it wraps after V_TOTAL rows (525 by default). Between two falling edges of `vsync_n_o` there are exactly V_TOTAL falling edges of `hsync_n_o`.
- R5: `vsync_n_o` is 0 exactly while the row, two clocks earlier, was in the range V_ACTIVE+V_FRONT up to but not including V_ACTIVE+V_FRONT+V_PULSE. By default that is rows 490 and 491.
- R6: A frame lasts H_TOTAL×V_TOTAL clocks: 420000 by default, or 59.52 Hz at 25 MHz. Falling edges of `vsync_n_o` are spaced by exactly that amount.
- R7: `pix_addr_o` equals row×H_ACTIVE+column in the same cycle whenever column < H_ACTIVE and row < V_ACTIVE. Outside that area it is 0, and it never reaches H_ACTIVE×V_ACTIVE.
- R8: For a visible position, the pixel presented on `pix_data_i` one clock after its address appears on the colour pins one clock later, in the same cycle as the sync levels decoded from that position. The mapping is `red_o` = bits 7:5, `green_o` = bits 4:2 and `blue_o` = bits 1:0.
- R9: For a position outside the visible area, all colour outputs are 0 whatever value `pix_data_i` carries. In particular they are 0 whenever either sync output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_addr_o | output | ADDR_W ($clog2(H_ACTIVE*V_ACTIVE), 19 by default) | Linear video RAM read address |
| pix_data_i | input | 8 | Pixel from video RAM, 3-3-2 packed, valid one clock after its address |
| red_o | output | 3 | Red level |
| green_o | output | 3 | Green level |
| blue_o | output | 2 | Blue level |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |

## Verification
The bench goes after the edges where the two counters interact. These are the last column of a line, the column where the row steps, the last visible row, and the frame wrap.

- A row counter that stepped at the line wrap instead of at the sync start would give sync pulses with the right width but vertical edges shifted against the horizontal ones.
- A missing delay stage would put colour and sync one clock apart.
- An off-by-one compare would stretch or shorten a pulse by a clock.

The bench drives random nonzero data during blanking, so any leak of colour into the porches shows up. A reset mid-frame checks that the timing restarts cleanly from column and row zero.

// File: rtl/vga_raster_pkg.sv
// Shared types for the raster controller.
// Assumes pixels are packed red-high, blue-low in one byte.
package vga_raster_pkg;

    // One pixel in 3-3-2 packing; bit order matches the RAM word.
    typedef struct packed {
        logic [2:0] red;
        logic [2:0] green;
        logic [1:0] blue;
    } rgb332_t;

    localparam rgb332_t RGB_BLACK = '0;

endpackage

// File: rtl/vga_axis_timer.sv
// One scan axis: a wrapping counter plus decode of the visible span and the
// active-low sync span. Used once for columns (step every clock) and once
// for rows (step on each horizontal sync start).
// Assumes ACTIVE, FRONT, PULSE and BACK are all at least 1.
module vga_axis_timer #(
    parameter int ACTIVE = 640,
    parameter int FRONT  = 16,
    parameter int PULSE  = 96,
    parameter int BACK   = 48,
    localparam int TOTAL = ACTIVE + FRONT + PULSE + BACK,
    localparam int CW    = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    output logic [CW-1:0] count_o,
    output logic          active_o,
    output logic          sync_n_o,
    output logic          pulse_start_o
);

    localparam int SYNC_BEG = ACTIVE + FRONT;
    localparam int SYNC_END = SYNC_BEG + PULSE;
    localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

    logic [CW-1:0] count_q;

    // Position counter: clears on reset, wraps after the last position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (step_i) begin
            count_q <= (count_q == LAST) ? '0 : count_q + CW'(1);
        end
    end

    // Span decode: visible area, sync window, and the step into sync.
    always_comb begin
        active_o      = (count_q < CW'(ACTIVE));
        sync_n_o      = !((count_q >= CW'(SYNC_BEG)) && (count_q < CW'(SYNC_END)));
        pulse_start_o = step_i && (count_q == CW'(SYNC_BEG - 1));
    end

    assign count_o = count_q;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LAST) else $error("axis count out of range"); // R2

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && count_q == LAST) |=> (count_q == '0)) else $error("axis wrap missed"); // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(count_q)) else $error("axis moved without step"); // R4

endmodule

// File: rtl/vga_addr_gen.sv
// Linear frame-buffer address from column and row: row*H_ACTIVE + column
// inside the visible area, zero elsewhere.
// Assumes row and column widths do not exceed the address width.
module vga_addr_gen #(
    parameter int H_ACTIVE = 640,
    parameter int V_ACTIVE = 480,
    parameter int HCW      = 10,
    parameter int VCW      = 10,
    localparam int ADDR_W  = $clog2(H_ACTIVE * V_ACTIVE)
) (
    input  logic [HCW-1:0]    col_i,
    input  logic [VCW-1:0]    row_i,
    input  logic              visible_i,
    output logic [ADDR_W-1:0] addr_o
);

    // Address arithmetic; the multiplier is by a constant.
    always_comb begin
        if (visible_i) begin
            addr_o = ADDR_W'(row_i) * ADDR_W'(H_ACTIVE) + ADDR_W'(col_i);
        end else begin
            addr_o = '0;
        end
    end

endmodule

// File: rtl/vga_out_stage.sv
// Output alignment. Stage one holds the sync and visible flags for the clock
// the RAM needs. Stage two registers all ten pins together, blanking the
// colour outside the visible area.
// Assumes pix_data_i belongs to the position whose flags sit in stage one.
module vga_out_stage
    import vga_raster_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hs_n_i,
    input  logic       vs_n_i,
    input  logic       visible_i,
    input  logic [7:0] pix_data_i,
    output logic       hsync_n_o,
    output logic       vsync_n_o,
    output logic [2:0] red_o,
    output logic [2:0] green_o,
    output logic [1:0] blue_o
);

    logic    hs_d, vs_d, vis_d;
    logic    hs_q, vs_q;
    rgb332_t rgb_q;
    logic [1:0] warm_q;

    // Stage one: wait out the RAM read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_d  <= 1'b1;
            vs_d  <= 1'b1;
            vis_d <= 1'b0;
        end else begin
            hs_d  <= hs_n_i;
            vs_d  <= vs_n_i;
            vis_d <= visible_i;
        end
    end

    // Stage two: glitch-free pins, colour gated by visibility.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q  <= 1'b1;
            vs_q  <= 1'b1;
            rgb_q <= RGB_BLACK;
        end else begin
            hs_q  <= hs_d;
            vs_q  <= vs_d;
            rgb_q <= vis_d ? rgb332_t'(pix_data_i) : RGB_BLACK;
        end
    end

    // Cycles since reset, saturating; gates the two-deep history checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    assign hsync_n_o = hs_q;
    assign vsync_n_o = vs_q;
    assign red_o     = rgb_q.red;
    assign green_o   = rgb_q.green;
    assign blue_o    = rgb_q.blue;

    AST_HS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_q |-> (rgb_q == RGB_BLACK)) else $error("colour during hsync"); // R9

    AST_VS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_q |-> (rgb_q == RGB_BLACK)) else $error("colour during vsync"); // R9

    AST_HIDDEN_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && !$past(visible_i, 2)) |-> (rgb_q == RGB_BLACK)) else $error("blanking leak"); // R9

    AST_HS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (hs_q == $past(hs_n_i, 2))) else $error("hsync misaligned"); // R3

endmodule

// File: rtl/vga_raster_ctrl.sv
// Top of the raster controller: column and row timers, frame-buffer address,
// and the aligned output stage.
// Assumes a video RAM with one clock of read latency on pix_data_i.
module vga_raster_ctrl #(
    parameter int H_ACTIVE = 640,
    parameter int H_FRONT  = 16,
    parameter int H_PULSE  = 96,
    parameter int H_BACK   = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FRONT  = 10,
    parameter int V_PULSE  = 2,
    parameter int V_BACK   = 33,
    localparam int ADDR_W  = $clog2(H_ACTIVE * V_ACTIVE)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] pix_addr_o,
    input  logic [7:0]        pix_data_i,
    output logic [2:0]        red_o,
    output logic [2:0]        green_o,
    output logic [1:0]        blue_o,
    output logic              hsync_n_o,
    output logic              vsync_n_o
);

    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_PULSE + H_BACK;
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_PULSE + V_BACK;
    localparam int HCW     = $clog2(H_TOTAL);
    localparam int VCW     = $clog2(V_TOTAL);

    logic [HCW-1:0] col;
    logic [VCW-1:0] row;
    logic           h_vis, v_vis, h_sync_n, v_sync_n;
    logic           h_start, v_start;
    logic           visible;

    vga_axis_timer #(
        .ACTIVE(H_ACTIVE), .FRONT(H_FRONT), .PULSE(H_PULSE), .BACK(H_BACK)
    ) u_col (
        .clk(clk), .rst_n(rst_n), .step_i(1'b1),
        .count_o(col), .active_o(h_vis), .sync_n_o(h_sync_n),
        .pulse_start_o(h_start)
    );

    // Rows step on each horizontal sync start, not at the line wrap.
    vga_axis_timer #(
        .ACTIVE(V_ACTIVE), .FRONT(V_FRONT), .PULSE(V_PULSE), .BACK(V_BACK)
    ) u_row (
        .clk(clk), .rst_n(rst_n), .step_i(h_start),
        .count_o(row), .active_o(v_vis), .sync_n_o(v_sync_n),
        .pulse_start_o(v_start)
    );

    assign visible = h_vis && v_vis;

    vga_addr_gen #(
        .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .HCW(HCW), .VCW(VCW)
    ) u_addr (
        .col_i(col), .row_i(row), .visible_i(visible), .addr_o(pix_addr_o)
    );

    vga_out_stage u_out (
        .clk(clk), .rst_n(rst_n),
        .hs_n_i(h_sync_n), .vs_n_i(v_sync_n), .visible_i(visible),
        .pix_data_i(pix_data_i),
        .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o),
        .red_o(red_o), .green_o(green_o), .blue_o(blue_o)
    );

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_addr_o < ADDR_W'(H_ACTIVE * V_ACTIVE)) else $error("address past frame"); // R7

    AST_ROW_ON_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        v_start |-> h_start) else $error("row event off hsync"); // R4

    AST_ADDR_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        !h_sync_n |-> (pix_addr_o == '0)) else $error("address during hsync"); // R7

endmodule

// File: tb/tb_vga_raster_ctrl.sv
module tb_vga_raster_ctrl;

    localparam int HA = 8, HF = 2, HP = 3, HB = 2;
    localparam int VA = 6, VF = 1, VP = 2, VB = 2;
    localparam int HT = HA + HF + HP + HB;
    localparam int VT = VA + VF + VP + VB;
    localparam int AW = $clog2(HA * VA);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] pix_addr;
    logic [7:0]    pix_data = 8'h00;
    logic [2:0]    red, green;
    logic [1:0]    blue;
    logic          hs_n, vs_n;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    vga_raster_ctrl #(
        .H_ACTIVE(HA), .H_FRONT(HF), .H_PULSE(HP), .H_BACK(HB),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_PULSE(VP), .V_BACK(VB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pix_addr_o(pix_addr), .pix_data_i(pix_data),
        .red_o(red), .green_o(green), .blue_o(blue),
        .hsync_n_o(hs_n), .vsync_n_o(vs_n)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_hs(input int h);
        return !((h >= HA + HF) && (h < HA + HF + HP));
    endfunction

    function automatic bit exp_vs(input int v);
        return !((v >= VA + VF) && (v < VA + VF + VP));
    endfunction

    function automatic int exp_addr(input int h, input int v);
        return (h < HA && v < VA) ? v * HA + h : 0;
    endfunction

    function automatic int pack_out(input logic [2:0] r, input logic [2:0] g, input logic [1:0] b);
        return int'({r, g, b});
    endfunction

    initial begin
        int  mh = 0, mv = 0;
        bit  p1_hs = 1, p1_vs = 1, p2_hs = 1, p2_vs = 1;
        int  p1_rgb = 0, p2_rgb = 0;
        bit  p1_vis = 0, p2_vis = 0;
        bit  prev_rst_low = 0;
        bit  prev_hs = 1, prev_vs = 1;
        int  hs_low = 0, hs_gap = 0, vs_gap = 0, hs_per_frame = 0;
        bit  seen_hf = 0, seen_vf = 0;
        logic [7:0] next_pix;
        void'($urandom(32'd20240611));
        for (int cyc = 0; cyc < 2400; cyc++) begin
            @(negedge clk);
            if (cyc >= 2) begin
                // R3 R5 R8 R9: outputs against the model two clocks back
                check("R3 hsync", int'(hs_n), int'(p2_hs));
                check("R5 vsync", int'(vs_n), int'(p2_vs));
                if (p2_vis) check("R8 colour", pack_out(red, green, blue), p2_rgb);
                else        check("R9 blank", pack_out(red, green, blue), 0);
                check("R7 address", int'(pix_addr), exp_addr(mh, mv));
                if (prev_rst_low) begin
                    check("R1 hs idle", int'(hs_n), 1);
                    check("R1 vs idle", int'(vs_n), 1);
                    check("R1 colour", pack_out(red, green, blue), 0);
                    check("R1 address", int'(pix_addr), 0);
                end
                // pulse width, line period, frame period, lines per frame
                if (!hs_n) hs_low++;
                if (hs_n && !prev_hs) begin
                    check("R3 pulse width", hs_low, HP);
                    hs_low = 0;
                end
                hs_gap++;
                vs_gap++;
                if (!hs_n && prev_hs) begin
                    if (seen_hf) check("R2 line period", hs_gap, HT);
                    seen_hf = 1;
                    hs_gap = 0;
                    hs_per_frame++;
                end
                if (!vs_n && prev_vs) begin
                    if (seen_vf) begin
                        check("R6 frame period", vs_gap, HT * VT);
                        check("R4 lines per frame", hs_per_frame, VT);
                    end
                    seen_vf = 1;
                    vs_gap = 0;
                    hs_per_frame = 0;
                end
                prev_hs = hs_n;
                prev_vs = vs_n;
            end
            // reset for this cycle: power-up and a mid-frame restart
            rst_n = !((cyc < 4) || (cyc >= 900 && cyc < 903));
            if (!rst_n) begin
                p1_hs = 1; p1_vs = 1; p1_rgb = 0; p1_vis = 0;
                p2_hs = 1; p2_vs = 1; p2_rgb = 0; p2_vis = 0;
                next_pix = 8'($urandom_range(1, 255));
                mh = 0; mv = 0;
                hs_low = 0; hs_gap = 0; vs_gap = 0; hs_per_frame = 0;
                seen_hf = 0; seen_vf = 0; prev_hs = 1; prev_vs = 1;
                prev_rst_low = 1;
            end else begin
                bit vis;
                vis = (mh < HA) && (mv < VA);
                if (vis) begin
                    if (exp_addr(mh, mv) == 0)      next_pix = 8'h00;
                    else if (exp_addr(mh, mv) % 7 == 0) next_pix = 8'hFF;
                    else next_pix = 8'($urandom_range(0, 255));
                end else begin
                    next_pix = 8'($urandom_range(1, 255));
                end
                p2_hs = p1_hs; p2_vs = p1_vs; p2_rgb = p1_rgb; p2_vis = p1_vis;
                p1_hs = exp_hs(mh); p1_vs = exp_vs(mv);
                p1_vis = vis; p1_rgb = vis ? int'(next_pix) : 0;
                // R4: row steps when the column enters the sync span
                if (mh == HA + HF - 1) mv = (mv == VT - 1) ? 0 : mv + 1;
                mh = (mh == HT - 1) ? 0 : mh + 1;
                prev_rst_low = 0;
            end
            @(posedge clk);
            #1 pix_data = next_pix;
        end
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule